// File: doc/BRIEF.md
# Custom Instruction Processing Engine

This block is the datapath behind a processor core's custom instruction slot. The core hands it two 32-bit operands and the 3-bit funct3 field of the instruction. The block returns one 32-bit result. The funct3 value picks one of eight fixed operations:

- inversion and arithmetic negation
- an unsigned multiply that keeps the low word
- reversal of the bit order, the byte order or the halfword order
- two merges that join one halfword from each operand

The handshake is minimal. A one-cycle `start` pulse presents the operands and the selector. On the next rising edge the result register loads, and `done` is high for exactly that one cycle. The result then stays unchanged until the next `start`. The core sees a fixed latency of one cycle and never stalls on the block.

Top module: `cix_engine`

## Requirements
- R1: A synchronous active-high reset sets `result` to 0 and `done` to 0 at the next clock edge.
- R2: `done` is high in the cycle after a clock edge that saw `start` high, and low after every edge that saw `start` low.
- R3: While `start` is low, `result` keeps its value.
- R4: With `funct_sel` = 0, the result is the bitwise inversion of `opnd_a`.
- R5: With `funct_sel` = 1, the result is the two's complement negation of `opnd_a`, modulo 2^32.
- R6: With `funct_sel` = 2, the result is the low 32 bits of the unsigned 64-bit product `opnd_a` * `opnd_b`.
- R7: With `funct_sel` = 3, the result is `opnd_a` with its bit order mirrored, so that bit i moves to bit 31-i.
- R8: With `funct_sel` = 4, the result is `opnd_a` with its four bytes in reverse order, so that bits [7:0] move to [31:24].
- R9: With `funct_sel` = 5, the result is `opnd_a` with its two 16-bit halves exchanged.
- R10: With `funct_sel` = 6, the result is {`opnd_a`[15:0], `opnd_b`[15:0]}.
- R11: With `funct_sel` = 7, the result is {`opnd_a`[31:16], `opnd_b`[31:16]}.
- R12: For `funct_sel` values 0, 1, 3, 4 and 5, the value of `opnd_b` has no effect on `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Single-cycle request that captures the operands and the selector |
| funct_sel | input | 3 | Operation select, taken from the instruction's funct3 field |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| result | output | 32 | Registered result |
| done | output | 1 | One-cycle pulse that marks a new result |

## Verification
Every selector value is driven with these operand patterns:

- all-zero, all-one and a lone MSB, which separate inversion from negation and expose a missing carry
- walking-one operands, which catch a mirrored bit, byte or halfword mapping, because each permutation moves a single set bit to a different place
- asymmetric byte patterns such as 0x12345678 with 0x9ABCDEF0, which show which operand and which half feed each merge field
- multiply pairs whose product overflows 32 bits, which check that the low word is kept

The unary operations are repeated with the same `opnd_a` and a changing `opnd_b`, which shows that the second operand is ignored. Idle cycles with noisy inputs between requests show that the result holds and that `done` does not pulse without a request.

// File: rtl/cix_pkg.sv
package cix_pkg;

  typedef enum logic [2:0] {
    OP_INV   = 3'd0,
    OP_NEG   = 3'd1,
    OP_MUL   = 3'd2,
    OP_BREV  = 3'd3,
    OP_YREV  = 3'd4,
    OP_HSWAP = 3'd5,
    OP_MLO   = 3'd6,
    OP_MHI   = 3'd7
  } cix_op_e;

  // Arithmetic helpers, kept as functions so each rule is stated once.
  function automatic logic [31:0] f_negate(input logic [31:0] v);
    return (~v) + 32'd1;
  endfunction

  function automatic logic [31:0] f_mul_lo(input logic [31:0] x, input logic [31:0] y);
    return x * y;
  endfunction

  function automatic logic [31:0] f_half_swap(input logic [31:0] v);
    return {v[15:0], v[31:16]};
  endfunction

  function automatic logic [31:0] f_join(input logic [15:0] hi, input logic [15:0] lo);
    return {hi, lo};
  endfunction

endpackage

// File: rtl/cix_permute.sv
module cix_permute #(
  parameter int DATA_W = 32,
  parameter int UNIT_W = 1
) (
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int UNITS = DATA_W / UNIT_W;

  // Mirror the order of UNIT_W-wide slices.
  for (genvar u = 0; u < UNITS; u++) begin : g_slice
    assign dout[(UNITS-1-u)*UNIT_W +: UNIT_W] = din[u*UNIT_W +: UNIT_W];
  end
endmodule

// File: rtl/cix_opunit.sv
module cix_opunit
  import cix_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [2:0]        sel,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] bit_rev;
  logic [DATA_W-1:0] byte_rev;

  cix_permute #(.DATA_W(DATA_W), .UNIT_W(1)) u_brev (.din(a), .dout(bit_rev));
  cix_permute #(.DATA_W(DATA_W), .UNIT_W(8)) u_yrev (.din(a), .dout(byte_rev));

  always_comb begin
    unique case (cix_op_e'(sel))
      OP_INV:   y = ~a;
      OP_NEG:   y = f_negate(a);
      OP_MUL:   y = f_mul_lo(a, b);
      OP_BREV:  y = bit_rev;
      OP_YREV:  y = byte_rev;
      OP_HSWAP: y = f_half_swap(a);
      OP_MLO:   y = f_join(a[HALF_W-1:0], b[HALF_W-1:0]);
      OP_MHI:   y = f_join(a[DATA_W-1:HALF_W], b[DATA_W-1:HALF_W]);
      default:  y = '0;
    endcase
  end
endmodule

// File: rtl/cix_resreg.sv
module cix_resreg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q,
  output logic              pulse
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q     <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= load;
      if (load) q <= d;
    end
  end
endmodule

// File: rtl/cix_engine.sv
module cix_engine #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        funct_sel,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic [DATA_W-1:0] result,
  output logic              done
);
  // Named internal events, visible to the bound checker.
  logic [DATA_W-1:0] op_value;
  logic              capture_fire;

  assign capture_fire = start;

  cix_opunit #(.DATA_W(DATA_W)) u_ops (
    .sel(funct_sel), .a(opnd_a), .b(opnd_b), .y(op_value)
  );

  cix_resreg #(.DATA_W(DATA_W)) u_res (
    .clk(clk), .rst(rst), .load(capture_fire), .d(op_value),
    .q(result), .pulse(done)
  );
endmodule

// File: rtl/cix_engine_chk.sv
module cix_engine_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [2:0]        funct_sel,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic [DATA_W-1:0] result,
  input logic              done,
  input logic [DATA_W-1:0] op_value,
  input logic              capture_fire
);
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (result == '0 && !done));
  a_r2_done_follows: assert property (@(posedge clk) disable iff (rst) capture_fire |=> done);
  a_r2_no_spurious:  assert property (@(posedge clk) disable iff (rst) !capture_fire |=> !done);
  a_r3_hold:         assert property (@(posedge clk) disable iff (rst) !start |=> $stable(result));
  a_r4_invert:       assert property (@(posedge clk) disable iff (rst)
                       (start && funct_sel == 3'd0) |=> (result == ~$past(opnd_a)));
  a_r5_negate:       assert property (@(posedge clk) disable iff (rst)
                       (start && funct_sel == 3'd1) |=> (result + $past(opnd_a) == '0));
  a_r9_swap:         assert property (@(posedge clk) disable iff (rst)
                       (start && funct_sel == 3'd5) |=>
                       (result[15:0] == $past(opnd_a[31:16]) && result[31:16] == $past(opnd_a[15:0])));
  a_r10_merge_lo:    assert property (@(posedge clk) disable iff (rst)
                       (start && funct_sel == 3'd6) |=>
                       (result == {$past(opnd_a[15:0]), $past(opnd_b[15:0])}));
  a_r11_merge_hi:    assert property (@(posedge clk) disable iff (rst)
                       (start && funct_sel == 3'd7) |=>
                       (result == {$past(opnd_a[31:16]), $past(opnd_b[31:16])}));
  a_r2_captures:     assert property (@(posedge clk) disable iff (rst)
                       capture_fire |=> (result == $past(op_value)));
endmodule

bind cix_engine cix_engine_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/cix_engine_tb.sv
module cix_engine_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  funct_sel = '0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [31:0] result;
  logic        done;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit finished = 1'b0;
  string tag = "R1";

  // Reference model state
  logic [31:0] m_result = '0;
  logic        m_done   = 1'b0;
  logic        m_valid  = 1'b0;
  logic [31:0] m_queue[$];

  always #10 clk = ~clk; // 50 MHz

  cix_engine u_dut (
    .clk(clk), .rst(rst), .start(start), .funct_sel(funct_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .done(done)
  );

  function automatic logic [31:0] ref_op(input int op, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r;
    longint unsigned p;
    r = '0;
    case (op)
      0: r = a ^ 32'hFFFF_FFFF;
      1: r = 32'd0 - a;
      2: begin p = longint'(a) * longint'(b); r = p[31:0]; end
      3: for (int i = 0; i < 32; i++) r[i] = a[31 - i];
      4: r = (a >> 24) | ((a >> 8) & 32'h0000_FF00) | ((a << 8) & 32'h00FF_0000) | (a << 24);
      5: r = (a >> 16) | (a << 16);
      6: r = (a << 16) | (b & 32'h0000_FFFF);
      7: r = (a & 32'hFFFF_0000) | (b >> 16);
      default: r = '0;
    endcase
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_result = '0;
      m_done   = 1'b0;
      m_valid  = 1'b1;
    end else begin
      m_done = start;
      if (start) begin
        m_result = ref_op(int'(funct_sel), opnd_a, opnd_b);
        m_queue.push_back(m_result);
      end
    end
  end

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    if (m_valid && !finished) begin
      n_checks++;
      if (result !== m_result || done !== m_done) begin
        n_fail++;
        $display("FAIL %s: result=%h done=%b expected result=%h done=%b",
                 tag, result, done, m_result, m_done);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1'b1;
      n_fail++;
      $display("FAIL watchdog: cycles=%0d expected < 20000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  task automatic issue(input int op, input logic [31:0] a, input logic [31:0] b, input string t);
    @(negedge clk);
    tag = t;
    start = 1'b1; funct_sel = 3'(op); opnd_a = a; opnd_b = b;
    @(negedge clk);
    start = 1'b0;
    opnd_a = ~a; opnd_b = b ^ 32'h5A5A_5A5A; funct_sel = 3'(op + 3);
    tag = "R3";
  endtask

  function automatic string op_tag(input int op);
    case (op)
      0: return "R4";  1: return "R5";  2: return "R6";  3: return "R7";
      4: return "R8";  5: return "R9";  6: return "R10"; default: return "R11";
    endcase
  endfunction

  initial begin
    logic [31:0] pats_a[6];
    logic [31:0] pats_b[6];
    logic [31:0] first_unary;
    pats_a = '{32'h0, 32'hFFFF_FFFF, 32'h8000_0000, 32'h1234_5678, 32'h0000_0001, 32'hDEAD_BEEF};
    pats_b = '{32'h0, 32'hFFFF_FFFF, 32'h0000_0003, 32'h9ABC_DEF0, 32'h8000_0000, 32'h0001_0003};
    tag = "R1";
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tag = "R2";
    repeat (2) @(negedge clk);

    for (int op = 0; op < 8; op++)
      for (int k = 0; k < 6; k++)
        issue(op, pats_a[k], pats_b[k], op_tag(op));

    for (int op = 0; op < 8; op++)
      for (int bitpos = 0; bitpos < 32; bitpos += 5)
        issue(op, 32'h1 << bitpos, 32'h1 << (31 - bitpos), op_tag(op));

    // R6: products wider than 32 bits keep the low word
    issue(2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R6");
    issue(2, 32'h0001_0000, 32'h0001_0000, "R6");

    // R12: unary operations ignore opnd_b
    foreach (pats_b[k]) begin
      issue(0, 32'hC0FF_EE01, pats_b[k], "R12");
      issue(1, 32'hC0FF_EE01, pats_b[k], "R12");
      issue(3, 32'hC0FF_EE01, pats_b[k], "R12");
      issue(4, 32'hC0FF_EE01, pats_b[k], "R12");
      issue(5, 32'hC0FF_EE01, pats_b[k], "R12");
    end

    // R3/R2: long idle with noisy inputs
    tag = "R3";
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      opnd_a = 32'h1111_1111 * 32'(i);
      funct_sel = 3'(i);
    end

    // Back-to-back requests (R2)
    @(negedge clk);
    tag = "R2";
    start = 1'b1; funct_sel = 3'd0; opnd_a = 32'h0F0F_0F0F;
    @(negedge clk);
    funct_sel = 3'd5; opnd_a = 32'hAAAA_5555;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);

    // R1: reset mid-run clears state
    tag = "R1";
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // Direct spot check of a known bit reversal (R7)
    issue(3, 32'h0000_0001, 32'h0, "R7");
    n_checks++;
    if (m_queue.size() == 0 || m_queue[$] !== 32'h8000_0000) begin
      n_fail++;
      $display("FAIL R7: model=%h expected=%h", m_queue[$], 32'h8000_0000);
    end
    first_unary = result;
    n_checks++;
    if (first_unary !== 32'h8000_0000) begin
      n_fail++;
      $display("FAIL R7: result=%h expected=%h", first_unary, 32'h8000_0000);
    end
    @(negedge clk);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule